// File: doc/BRIEF.md
# USB OUT Control Endpoint Register and Handshake Selector

This block holds the 32-bit control and status word of a device-side OUT control endpoint. It also decides, every cycle, which handshake the endpoint would return to an OUT data packet. Software writes the word through a simple register port: a write strobe, 32 bits of write data and four byte-lane enables. The current word is always visible on the read-data output.

The protocol engine feeds in single-cycle event pulses: SETUP token seen, SETUP stage finished, transfer finished and endpoint disabled. It also supplies a level showing that the receive FIFO has room. From these inputs the block drives the handshake choice, an accept strobe, an accept-without-check strobe for snoop operation, a constant endpoint-active flag and the enable state.

The NAK state is sticky. It can only be changed through separate write-only set and clear bits. STALL can only be raised by software and is dropped by a SETUP token. The enable bit clears itself when the endpoint finishes its work.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After reset the read data is 0x0000_8000, `epEnable` is 0, and with `rxSpace` high the handshake is ACK (`hsSel` 2'b00) with `acceptData` 1.
- R2: Bit 15 always reads 1 and `epActive` is always 1. Bits 19:18 (endpoint type) always read 00. Bits 16, 25:22 and 29:28 always read 0, even after writes of all ones.
- R3: A written 1 in bit 27 sets the NAK status (bit 17), and a written 1 in bit 26 clears it. Bits 27 and 26 always read 0. If both are written as 1 in the same write, the status ends up set.
- R4: While NAK status is 1 and STALL is 0, `hsSel` is NAK (2'b01) and `acceptData` is 0, whatever the value of `rxSpace`.
- R5: While NAK status and STALL are both 0, `hsSel` is ACK with `acceptData` 1 when `rxSpace` is 1. When `rxSpace` is 0, `hsSel` is NAK with `acceptData` 0.
- R6: A written 1 in bit 21 sets STALL, and a written 0 there has no effect. A `setupTok` pulse clears STALL. When a `setupTok` pulse and a STALL write fall in the same cycle, STALL ends up 0.
- R7: While STALL is 1, `hsSel` is STALL (2'b10) and `acceptData` is 0, whatever the NAK status or `rxSpace`.
- R8: A written 1 in bit 31 sets enable, which `epEnable` mirrors, and a written 0 has no effect. Each of `setupDone`, `xferDone` and `epDisabled` clears enable. A clear pulse wins over a same-cycle write of 1.
- R9: A written 1 in bit 30 (disable request) takes effect only if enable was already 1 before that write, and a written 0 has no effect. An `epDisabled` pulse clears bit 30.
- R10: Bit 20 (snoop) is read/write. `acceptNoCheck` is 1 exactly when snoop is 1 and `acceptData` is 1.
- R11: A write changes only the bits in byte lanes whose `regByteEn` bit is 1. Lane n covers bits 8n+7:8n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrite | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regByteEn | input | 4 | Byte-lane write enables |
| regRdata | output | 32 | Current register word |
| setupTok | input | 1 | SETUP token received pulse |
| setupDone | input | 1 | SETUP stage complete pulse |
| xferDone | input | 1 | Transfer complete pulse |
| epDisabled | input | 1 | Endpoint disabled event pulse |
| rxSpace | input | 1 | Receive FIFO has room |
| hsSel | output | 2 | Handshake: 00 ACK, 01 NAK, 10 STALL |
| acceptData | output | 1 | Incoming OUT data is taken |
| acceptNoCheck | output | 1 | Data is taken without a correctness check |
| epActive | output | 1 | Endpoint active, constant 1 |
| epEnable | output | 1 | Endpoint enable state |

## Verification
Every storage bit appears on `regRdata` through combinational logic, so a flag held in a wrong state shows up on the read port in the cycle after the edge that set it. The handshake outputs depend only on stored flags and `rxSpace`, so a wrong NAK or STALL flag, or a wrong priority between them, changes `hsSel` and `acceptData` in that same cycle. Races between a software write and a hardware event are settled at a single edge, and the result can be read on the next sample.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  localparam int REG_W      = 32;
  localparam int BIT_ACTIVE = 15;
  localparam int BIT_NAKST  = 17;
  localparam int BIT_SNOOP  = 20;
  localparam int BIT_STALL  = 21;
  localparam int BIT_NAKCLR = 26;
  localparam int BIT_NAKSET = 27;
  localparam int BIT_DISREQ = 30;
  localparam int BIT_EN     = 31;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hsSel_e;

  // Strobes passed from the control decoder to the state datapath
  typedef struct packed {
    logic nakSet;
    logic nakClr;
    logic stallSet;
    logic stallClr;
    logic enSet;
    logic enClr;
    logic disSet;
    logic disClr;
    logic snoopWr;
    logic snoopVal;
  } epStrobes_t;

endpackage

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
  import usb_ep_pkg::*;
#(
  parameter int REG_W = 32,
  localparam int LANES = REG_W / 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrite,
  input  logic [REG_W-1:0]   regWdata,
  input  logic [LANES-1:0]   regByteEn,
  input  logic               setupTok,
  input  logic               setupDone,
  input  logic               xferDone,
  input  logic               epDisabled,
  input  logic               curEn,
  output epStrobes_t         strb
);

  logic [LANES-1:0] laneOn;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneOn[g] = regWrite & regByteEn[g];
  end

  function automatic logic laneOf(input logic [LANES-1:0] lanes, input int bitPos);
    return lanes[bitPos / 8];
  endfunction

  always_comb begin
    strb          = '0;
    strb.nakSet   = laneOf(laneOn, BIT_NAKSET) & regWdata[BIT_NAKSET];
    strb.nakClr   = laneOf(laneOn, BIT_NAKCLR) & regWdata[BIT_NAKCLR];
    strb.stallSet = laneOf(laneOn, BIT_STALL)  & regWdata[BIT_STALL];
    strb.stallClr = setupTok;
    strb.enSet    = laneOf(laneOn, BIT_EN)     & regWdata[BIT_EN];
    strb.enClr    = setupDone | xferDone | epDisabled;
    strb.disSet   = laneOf(laneOn, BIT_DISREQ) & regWdata[BIT_DISREQ] & curEn;
    strb.disClr   = epDisabled;
    strb.snoopWr  = laneOf(laneOn, BIT_SNOOP);
    strb.snoopVal = regWdata[BIT_SNOOP];
  end

  logic unusedData;
  assign unusedData = ^{regWdata[19:0], regWdata[25:22], regWdata[29:28]};

  // The disable request is passed on only while enable is already on
  AST_DIS_GATED: assert property (@(posedge clk) disable iff (!rstN)
    strb.disSet |-> curEn); // R9

endmodule

// File: rtl/usb_ep_dp.sv
module usb_ep_dp
  import usb_ep_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  epStrobes_t       strb,
  output logic             nakSt,
  output logic             stall,
  output logic             en,
  output logic             disReq,
  output logic             snoop,
  output logic [REG_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nakSt  <= 1'b0;
      stall  <= 1'b0;
      en     <= 1'b0;
      disReq <= 1'b0;
      snoop  <= 1'b0;
    end else begin
      // Set wins over clear for the sticky NAK flag
      if (strb.nakSet)        nakSt <= 1'b1;
      else if (strb.nakClr)   nakSt <= 1'b0;
      // A SETUP token wins over a software STALL write
      if (strb.stallClr)      stall <= 1'b0;
      else if (strb.stallSet) stall <= 1'b1;
      // Hardware completion wins over a software enable write
      if (strb.enClr)         en <= 1'b0;
      else if (strb.enSet)    en <= 1'b1;
      if (strb.disClr)        disReq <= 1'b0;
      else if (strb.disSet)   disReq <= 1'b1;
      if (strb.snoopWr)       snoop <= strb.snoopVal;
    end
  end

  always_comb begin
    rdata             = '0;
    rdata[BIT_ACTIVE] = 1'b1;
    rdata[BIT_NAKST]  = nakSt;
    rdata[BIT_SNOOP]  = snoop;
    rdata[BIT_STALL]  = stall;
    rdata[BIT_DISREQ] = disReq;
    rdata[BIT_EN]     = en;
  end

  AST_NAK_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.nakSet |=> nakSt); // R3
  AST_STALL_SETUP_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.stallClr |=> !stall); // R6
  AST_EN_HW_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.enClr |=> !en); // R8
  AST_DIS_AFTER_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(disReq) |-> $past(en)); // R9
  AST_DIS_EVT_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.disClr |=> !disReq); // R9

endmodule

// File: rtl/usb_ep_hs.sv
module usb_ep_hs
  import usb_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       nakSt,
  input  logic       stall,
  input  logic       snoop,
  input  logic       rxSpace,
  output logic [1:0] hsSel,
  output logic       acceptData,
  output logic       acceptNoCheck
);

  hsSel_e pick;

  always_comb begin
    if (stall)                  pick = HS_STALL;
    else if (nakSt || !rxSpace) pick = HS_NAK;
    else                        pick = HS_ACK;
  end

  assign hsSel         = pick;
  assign acceptData    = (pick == HS_ACK);
  assign acceptNoCheck = acceptData & snoop;

  AST_STALL_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (hsSel == 2'b10) && !acceptData); // R7
  AST_NAK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    nakSt |-> !acceptData); // R4
  AST_NOCHECK_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    acceptNoCheck |-> acceptData && snoop); // R10

endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl
  import usb_ep_pkg::*;
#(
  parameter int REG_W = 32,
  localparam int LANES = REG_W / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrite,
  input  logic [REG_W-1:0] regWdata,
  input  logic [LANES-1:0] regByteEn,
  output logic [REG_W-1:0] regRdata,
  input  logic             setupTok,
  input  logic             setupDone,
  input  logic             xferDone,
  input  logic             epDisabled,
  input  logic             rxSpace,
  output logic [1:0]       hsSel,
  output logic             acceptData,
  output logic             acceptNoCheck,
  output logic             epActive,
  output logic             epEnable
);

  epStrobes_t strb;
  logic nakSt, stall, en, disReq, snoop;

  usb_ep_ctrl #(.REG_W(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regWdata(regWdata),
    .regByteEn(regByteEn), .setupTok(setupTok), .setupDone(setupDone),
    .xferDone(xferDone), .epDisabled(epDisabled), .curEn(en), .strb(strb)
  );

  usb_ep_dp #(.REG_W(REG_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .nakSt(nakSt), .stall(stall),
    .en(en), .disReq(disReq), .snoop(snoop), .rdata(regRdata)
  );

  usb_ep_hs uHs (
    .clk(clk), .rstN(rstN), .nakSt(nakSt), .stall(stall), .snoop(snoop),
    .rxSpace(rxSpace), .hsSel(hsSel), .acceptData(acceptData),
    .acceptNoCheck(acceptNoCheck)
  );

  assign epActive = 1'b1;
  assign epEnable = en;

  logic unusedDis;
  assign unusedDis = disReq;

  AST_ACTIVE_ON: assert property (@(posedge clk) disable iff (!rstN)
    epActive && regRdata[15] && (regRdata[19:18] == 2'b00)); // R2

endmodule

// File: tb/sim_usb_out_ep_ctrl.sv
`timescale 1ns/1ps
module sim_usb_out_ep_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic [31:0] regWdata = '0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regRdata;
  logic        setupTok = 1'b0, setupDone = 1'b0, xferDone = 1'b0, epDisabled = 1'b0;
  logic        rxSpace = 1'b1;
  logic [1:0]  hsSel;
  logic        acceptData, acceptNoCheck, epActive, epEnable;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  usb_out_ep_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regWdata(regWdata),
    .regByteEn(regByteEn), .regRdata(regRdata), .setupTok(setupTok),
    .setupDone(setupDone), .xferDone(xferDone), .epDisabled(epDisabled),
    .rxSpace(rxSpace), .hsSel(hsSel), .acceptData(acceptData),
    .acceptNoCheck(acceptNoCheck), .epActive(epActive), .epEnable(epEnable)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // One clock of stimulus: inputs set at a falling edge, released at the next
  task automatic cyc(input logic wr, input logic [31:0] d, input logic [3:0] be,
                     input logic su, input logic sd, input logic xd, input logic ed);
    @(negedge clk);
    regWrite = wr; regWdata = d; regByteEn = be;
    setupTok = su; setupDone = sd; xferDone = xd; epDisabled = ed;
    @(negedge clk);
    regWrite = 1'b0; regWdata = '0; regByteEn = '0;
    setupTok = 1'b0; setupDone = 1'b0; xferDone = 1'b0; epDisabled = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] be);
    cyc(1'b1, d, be, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; rxSpace = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tReset();
    doReset();
    chk("R1 rdata", regRdata, 32'h0000_8000);
    chk("R1 epEnable", {31'b0, epEnable}, 0);
    chk("R1 hsSel", {30'b0, hsSel}, 0);
    chk("R1 acceptData", {31'b0, acceptData}, 1);
    chk("R2 epActive", {31'b0, epActive}, 1);
  endtask

  task automatic tFixedBits();
    doReset();
    wr(32'hFFFF_FFFF, 4'hF);
    // en=1, stall=1, snoop=1, nak=1 (set wins), active=1; disable blocked since en was 0
    chk("R2/R3 all-ones write", regRdata, 32'h8032_8000);
    chk("R2 epActive", {31'b0, epActive}, 1);
  endtask

  task automatic tNak();
    doReset();
    wr(32'h0800_0000, 4'h8);
    chk("R3 nak set", regRdata, 32'h0002_8000);
    rxSpace = 1'b1; #1;
    chk("R4 hs nak with space", {30'b0, hsSel}, 1);
    chk("R4 no accept", {31'b0, acceptData}, 0);
    wr(32'h0400_0000, 4'h8);
    chk("R3 nak clear", regRdata, 32'h0000_8000);
    chk("R5 ack", {30'b0, hsSel}, 0);
    chk("R5 accept", {31'b0, acceptData}, 1);
    rxSpace = 1'b0; #1;
    chk("R5 full nak", {30'b0, hsSel}, 1);
    chk("R5 full no accept", {31'b0, acceptData}, 0);
    rxSpace = 1'b1;
    wr(32'h0C00_0000, 4'h8);
    chk("R3 set and clear together", regRdata, 32'h0002_8000);
  endtask

  task automatic tStall();
    doReset();
    wr(32'h0020_0000, 4'h4);
    chk("R6 stall set", regRdata, 32'h0020_8000);
    chk("R7 hs stall", {30'b0, hsSel}, 2);
    chk("R7 no accept", {31'b0, acceptData}, 0);
    wr(32'h0800_0000, 4'h8);
    chk("R7 stall over nak", {30'b0, hsSel}, 2);
    wr(32'h0000_0000, 4'h4);
    chk("R6 write 0 ignored", regRdata, 32'h0022_8000);
    cyc(1'b0, '0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6 setup clears", regRdata, 32'h0002_8000);
    chk("R4 back to nak", {30'b0, hsSel}, 1);
    cyc(1'b1, 32'h0020_0000, 4'h4, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6 setup wins over write", regRdata, 32'h0002_8000);
  endtask

  task automatic tEnable();
    doReset();
    wr(32'h8000_0000, 4'h8);
    chk("R8 en set", regRdata, 32'h8000_8000);
    chk("R8 epEnable", {31'b0, epEnable}, 1);
    wr(32'h0000_0000, 4'hF);
    chk("R8 write 0 ignored", {31'b0, epEnable}, 1);
    cyc(1'b0, '0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 setupDone clears", {31'b0, epEnable}, 0);
    wr(32'h8000_0000, 4'h8);
    cyc(1'b0, '0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 xferDone clears", {31'b0, epEnable}, 0);
    wr(32'h8000_0000, 4'h8);
    cyc(1'b0, '0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 epDisabled clears", {31'b0, epEnable}, 0);
    cyc(1'b1, 32'h8000_0000, 4'h8, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 hw clear wins", regRdata, 32'h0000_8000);
  endtask

  task automatic tDisable();
    doReset();
    wr(32'h4000_0000, 4'h8);
    chk("R9 blocked while disabled", regRdata, 32'h0000_8000);
    wr(32'hC000_0000, 4'h8);
    chk("R9 blocked with same-write en", regRdata, 32'h8000_8000);
    wr(32'h4000_0000, 4'h8);
    chk("R9 set while enabled", regRdata, 32'hC000_8000);
    wr(32'h0000_0000, 4'h8);
    chk("R9 write 0 ignored", regRdata, 32'hC000_8000);
    cyc(1'b0, '0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 event clears", regRdata, 32'h0000_8000);
  endtask

  task automatic tSnoop();
    doReset();
    wr(32'h0010_0000, 4'h4);
    chk("R10 snoop set", regRdata, 32'h0010_8000);
    chk("R10 nocheck with space", {31'b0, acceptNoCheck}, 1);
    rxSpace = 1'b0; #1;
    chk("R10 nocheck full", {31'b0, acceptNoCheck}, 0);
    rxSpace = 1'b1;
    wr(32'h0800_0000, 4'h8);
    chk("R10 nocheck under nak", {31'b0, acceptNoCheck}, 0);
    wr(32'h0000_0000, 4'h4);
    chk("R10 snoop cleared", regRdata, 32'h0002_8000);
  endtask

  task automatic tLanes();
    doReset();
    wr(32'hFFFF_FFFF, 4'h3);
    chk("R11 low lanes no effect", regRdata, 32'h0000_8000);
    wr(32'hFFFF_FFFF, 4'h4);
    chk("R11 lane 2 only", regRdata, 32'h0030_8000);
    wr(32'hFFFF_FFFF, 4'h8);
    chk("R11 lane 3 only", regRdata, 32'h8032_8000);
  endtask

  initial begin
    tReset();
    tFixedBits();
    tNak();
    tStall();
    tEnable();
    tDisable();
    tSnoop();
    tLanes();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule